// File: doc/BRIEF.md
# Polled EEPROM Byte Writer

This engine sits on the host side of a serial programming link and writes one EEPROM byte at a time into a target device. A caller presents an address and a data byte with a start strobe. The engine sends a four-byte write instruction through an internal byte shifter. It then decides when the target can take the next byte, and signals that moment with a one-cycle completion pulse.

For most data values the engine works out completion by reading the same address back, again and again. While the target is still busy, it first reports one fixed marker value during its internal auto-erase and then a second marker value during programming. When the readback equals the written byte, the write is finished. A byte equal to either marker cannot be told apart from the markers, so the engine does not poll for it; it waits a fixed number of cycles instead. If polling runs longer than a set limit, the engine gives up and raises an error flag together with the completion pulse.

The caller can also report that the target was chip-erased just before. In that case a 0xFF byte is already in place, so the engine completes it at once without touching the serial lines. Without that report, 0xFF is written and polled like any other value.

Top module: `ee_poll_writer`

## Requirements
- R1: After reset `busy`, `done`, `err`, `sck` and `mosi` are all 0.
- R2: Every instruction is 32 bits, sent most significant bit first. `mosi` changes only while `sck` is low and holds steady while `sck` is high. A write instruction is the bytes WR_OP, the address upper byte (zero-extended), the address lower byte, then the data.
- R3: After a write whose data is neither P1_VAL nor P2_VAL, the engine issues read instructions (RD_OP, address upper byte, address lower byte, 0x00). It samples the target's reply during the fourth byte on rising `sck`. It repeats the read until the reply equals the data, so it observes both marker values while the target is busy.
- R4: The completion pulse for a polled byte never comes before the target has finished programming that byte.
- R5: When the data equals P1_VAL or P2_VAL, no read instruction is issued. `done` pulses between T_WD and T_WD+20 cycles after the final falling `sck` edge of the write instruction.
- R6: When `erased_valid` is 1 and the data is 0xFF, no `sck` edge occurs and `done` pulses within 3 cycles of acceptance. `erased_valid` alone, with any other data, does not suppress the write.
- R7: With `erased_valid` at 0, a 0xFF byte is written and polled like any other value.
- R8: `start` is accepted only while `busy` is 0. A strobe made while `busy` is 1 starts no instruction and produces no completion.
- R9: If no matching readback arrives within POLL_LIMIT cycles of the end of the write instruction, `err` is set in the same cycle as `done` and stays set. The next accepted byte clears it.
- R10: `done` is a single-cycle pulse, issued exactly once per accepted byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to write one byte (taken only when idle) |
| addr | input | ADDR_W | Target EEPROM address |
| wdata | input | 8 | Byte to write |
| erased_valid | input | 1 | Target is known to be freshly chip-erased |
| busy | output | 1 | Engine is occupied; start is ignored |
| done | output | 1 | One-cycle pulse: byte finished or skipped |
| err | output | 1 | Polling gave up on the most recent byte |
| sck | output | 1 | Serial clock to the target |
| mosi | output | 1 | Serial data to the target |
| miso | input | 1 | Serial data from the target |

## Verification
The hardest case to reach from the ports is the polling timeout, because a working target always ends its write. The bench target model can be told to get stuck on one address, returning the programming marker forever and never storing the byte. That drives the engine through thousands of cycles of reads until its limit runs out. Reaching the marker-valued path also needs the model to run its erase and programming phases on a cycle clock. Only then does a timed wait, rather than a poll, show up as missing read traffic and a measured gap.

// File: rtl/ee_pkg.sv
package ee_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_WRITE,
        WS_POLL,
        WS_TWAIT
    } ws_e;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH
    } sh_e;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SEND,
        FR_WAIT
    } fr_e;

endpackage

// File: rtl/ee_byte_shifter.sv
module ee_byte_shifter
    import ee_pkg::*;
#(
    parameter int HALF_PER = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int DIV_W = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PER - 1);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    typedef struct packed {
        sh_e               st;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic [BIT_W-1:0]  bitn;
        logic [DIV_W-1:0]  div;
        logic              sck;
        logic              done;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            SH_IDLE: begin
                if (go) begin
                    d.st   = SH_LOW;
                    d.tx   = tx_byte;
                    d.div  = '0;
                    d.bitn = '0;
                    d.sck  = 1'b0;
                end
            end
            SH_LOW: begin
                if (q.div == DIV_LAST) begin
                    d.div = '0;
                    d.sck = 1'b1;
                    d.rx  = {q.rx[BYTE_W-2:0], miso};
                    d.st  = SH_HIGH;
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            SH_HIGH: begin
                if (q.div == DIV_LAST) begin
                    d.div = '0;
                    d.sck = 1'b0;
                    if (q.bitn == BIT_LAST) begin
                        d.st   = SH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.bitn = q.bitn + 1'b1;
                        d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
                        d.st   = SH_LOW;
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            default: d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.sck;
    assign mosi    = (q.st != SH_IDLE) & q.tx[BYTE_W-1];
    assign done    = q.done;
    assign rx_byte = q.rx;

    // R2: data may not move while the clock is high
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/ee_frame_seq.sv
module ee_frame_seq
    import ee_pkg::*;
#(
    parameter int FRAME_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [FRAME_BYTES*BYTE_W-1:0] frame,
    input  logic                          sh_done,
    input  logic [BYTE_W-1:0]             sh_rx,
    output logic                          sh_go,
    output logic [BYTE_W-1:0]             sh_byte,
    output logic                          done,
    output logic [BYTE_W-1:0]             rx_last
);
    localparam int FW    = FRAME_BYTES * BYTE_W;
    localparam int IDX_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BYTES - 1);

    typedef struct packed {
        fr_e               st;
        logic [IDX_W-1:0]  idx;
        logic [FW-1:0]     word;
        logic              done;
        logic [BYTE_W-1:0] rx;
    } fr_t;

    fr_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            FR_IDLE: begin
                if (go) begin
                    d.st   = FR_SEND;
                    d.idx  = '0;
                    d.word = frame;
                end
            end
            FR_SEND: d.st = FR_WAIT;
            FR_WAIT: begin
                if (sh_done) begin
                    if (q.idx == IDX_LAST) begin
                        d.rx   = sh_rx;
                        d.done = 1'b1;
                        d.st   = FR_IDLE;
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.word = {q.word[FW-BYTE_W-1:0], {BYTE_W{1'b0}}};
                        d.st   = FR_SEND;
                    end
                end
            end
            default: d.st = FR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sh_go   = (q.st == FR_SEND);
    assign sh_byte = q.word[FW-1 -: BYTE_W];
    assign done    = q.done;
    assign rx_last = q.rx;

    // R3: each instruction ends with exactly one completion strobe
    p_frame_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/ee_wait_timer.sv
module ee_wait_timer #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tm_t;

    tm_t d, q;

    always_comb begin
        d = q;
        if (load)            d.cnt = load_val;
        else if (q.cnt != 0) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = (q.cnt == '0);

    // R5: once loaded the count falls by one per cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !expired) |=> (q.cnt == $past(q.cnt) - 1'b1));

endmodule

// File: rtl/ee_poll_writer.sv
module ee_poll_writer
    import ee_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          HALF_PER   = 2,
    parameter logic [7:0]  WR_OP      = 8'hC0,
    parameter logic [7:0]  RD_OP      = 8'hA0,
    parameter logic [7:0]  P1_VAL     = 8'h80,
    parameter logic [7:0]  P2_VAL     = 8'h7F,
    parameter int          T_WD       = 4000,
    parameter int          POLL_LIMIT = 6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              erased_valid,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    localparam int FRAME_BYTES = 4;
    localparam int FW          = FRAME_BYTES * BYTE_W;
    localparam int TMR_MAX     = (T_WD > POLL_LIMIT) ? T_WD : POLL_LIMIT;
    localparam int TMR_W       = $clog2(TMR_MAX + 1);
    localparam logic [7:0] ERASED = 8'hFF;

    typedef struct packed {
        ws_e               st;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              rd;
        logic              fr_go;
        logic              tmr_load;
        logic [TMR_W-1:0]  tmr_val;
        logic              done;
        logic              err;
    } wr_t;

    wr_t d, q;

    logic [15:0]       addr16;
    logic [FW-1:0]     fr_word;
    logic              fr_done;
    logic [7:0]        fr_rx;
    logic              sh_go;
    logic [7:0]        sh_byte;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              tmr_expired;
    logic              marker_data;
    logic              accept;

    assign addr16      = 16'(q.addr);
    assign fr_word     = {q.rd ? RD_OP : WR_OP, addr16[15:8], addr16[7:0],
                          q.rd ? 8'h00 : q.data};
    assign marker_data = (q.data == P1_VAL) || (q.data == P2_VAL);
    assign accept      = (q.st == WS_IDLE) && !q.done && start;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.fr_go    = 1'b0;
        d.tmr_load = 1'b0;
        case (q.st)
            WS_IDLE: begin
                if (accept) begin
                    d.addr = addr;
                    d.data = wdata;
                    d.err  = 1'b0;
                    if (erased_valid && wdata == ERASED) begin
                        d.done = 1'b1;
                    end else begin
                        d.rd    = 1'b0;
                        d.fr_go = 1'b1;
                        d.st    = WS_WRITE;
                    end
                end
            end
            WS_WRITE: begin
                if (fr_done) begin
                    d.tmr_load = 1'b1;
                    if (marker_data) begin
                        d.tmr_val = TMR_W'(T_WD);
                        d.st      = WS_TWAIT;
                    end else begin
                        d.tmr_val = TMR_W'(POLL_LIMIT);
                        d.rd      = 1'b1;
                        d.fr_go   = 1'b1;
                        d.st      = WS_POLL;
                    end
                end
            end
            WS_POLL: begin
                if (fr_done) begin
                    if (fr_rx == q.data) begin
                        d.done = 1'b1;
                        d.st   = WS_IDLE;
                    end else if (tmr_expired) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                        d.st   = WS_IDLE;
                    end else begin
                        d.fr_go = 1'b1;
                    end
                end
            end
            WS_TWAIT: begin
                if (!q.tmr_load && tmr_expired) begin
                    d.done = 1'b1;
                    d.st   = WS_IDLE;
                end
            end
            default: d.st = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    ee_frame_seq #(
        .FRAME_BYTES (FRAME_BYTES)
    ) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (q.fr_go),
        .frame   (fr_word),
        .sh_done (sh_done),
        .sh_rx   (sh_rx),
        .sh_go   (sh_go),
        .sh_byte (sh_byte),
        .done    (fr_done),
        .rx_last (fr_rx)
    );

    ee_byte_shifter #(
        .HALF_PER (HALF_PER)
    ) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_byte),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    ee_wait_timer #(
        .W (TMR_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (q.tmr_load),
        .load_val (q.tmr_val),
        .expired  (tmr_expired)
    );

    assign busy = (q.st != WS_IDLE) || q.done;
    assign done = q.done;
    assign err  = q.err;

    // R10: completion never lasts two cycles
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a strobe while occupied leaves the latched request untouched
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.addr) && $stable(q.data)));

    // R9: the error flag only appears together with completion
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    // R6: erased 0xFF completes on the next cycle with the state machine idle
    p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && erased_valid && wdata == 8'hFF) |=> (done && q.st == WS_IDLE));

    // R5: no serial activity during the timed wait
    p_twait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == WS_TWAIT) |-> !sck);

endmodule

// File: tb/test_ee_poll_writer.sv
module test_ee_poll_writer;

    localparam int         ADDR_W = 12;
    localparam int         HALF   = 2;
    localparam logic [7:0] WR     = 8'hC0;
    localparam logic [7:0] RD     = 8'hA0;
    localparam logic [7:0] P1     = 8'h80;
    localparam logic [7:0] P2     = 8'h7F;
    localparam int         TWD    = 4000;
    localparam int         PLIM   = 6000;
    localparam int         T_ER   = 300;
    localparam int         T_PG   = 700;
    localparam int         WDOG   = 150000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              start;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic              erased_valid;
    logic              busy, done, err, sck, mosi;
    logic              miso;

    ee_poll_writer #(
        .ADDR_W (ADDR_W), .HALF_PER (HALF), .WR_OP (WR), .RD_OP (RD),
        .P1_VAL (P1), .P2_VAL (P2), .T_WD (TWD), .POLL_LIMIT (PLIM)
    ) i_ee_poll_writer (
        .clk (clk), .rst_n (rst_n), .start (start), .addr (addr),
        .wdata (wdata), .erased_valid (erased_valid), .busy (busy),
        .done (done), .err (err), .sck (sck), .mosi (mosi), .miso (miso)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // target model state, all owned by one process
    logic [7:0]  mem [0:4095];
    int          cyc = 0;
    logic        sck_prev;
    logic [31:0] sin;
    int          bitn;
    logic [7:0]  osh;
    logic        wr_act;
    int          wr_t0, fin_t;
    logic [11:0] wr_a;
    logic [7:0]  wr_d;
    int          wr_frames, rd_frames, bad_frames, n_p1, n_p2, sck_falls, last_fall;
    int          done_cnt, done_t, pulse_bad;
    logic        done_prev, done_err;
    logic        stuck;
    logic [11:0] stuck_a;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
            sck_prev = 1'b0; sin = '0; bitn = 0; osh = '0; miso = 1'b0;
            wr_act = 1'b0; wr_t0 = 0; fin_t = 0; wr_a = '0; wr_d = '0;
            wr_frames = 0; rd_frames = 0; bad_frames = 0; n_p1 = 0; n_p2 = 0;
            sck_falls = 0; last_fall = 0; done_cnt = 0; done_t = 0;
            pulse_bad = 0; done_prev = 1'b0; done_err = 1'b0;
        end else begin
            if (done) begin
                done_cnt++;
                done_t   = cyc;
                done_err = err;
                if (done_prev) pulse_bad++;
            end
            done_prev = done;
            if (wr_act && cyc >= wr_t0 + T_ER + T_PG) begin
                mem[wr_a] = wr_d;
                wr_act    = 1'b0;
                fin_t     = cyc;
            end
            if (sck && !sck_prev) begin
                sin = {sin[30:0], mosi};
                bitn++;
                if (bitn == 32) begin
                    bitn = 0;
                    if (sin[31:24] == WR) begin
                        wr_frames++;
                        if (sin[23:20] != 4'h0) bad_frames++;
                        if (!stuck) begin
                            wr_act = 1'b1; wr_t0 = cyc;
                            wr_a = sin[19:8]; wr_d = sin[7:0];
                        end
                    end else if (sin[31:24] == RD) begin
                        rd_frames++;
                        if (sin[7:0] != 8'h00 || sin[23:20] != 4'h0) bad_frames++;
                    end else begin
                        bad_frames++;
                    end
                end
            end
            if (!sck && sck_prev) begin
                sck_falls++;
                last_fall = cyc;
                if (bitn == 24 && sin[23:16] == RD) begin
                    if (stuck && sin[11:0] == stuck_a) begin
                        osh = P2; n_p2++;
                    end else if (wr_act && sin[11:0] == wr_a) begin
                        if (cyc < wr_t0 + T_ER) begin osh = P1; n_p1++; end
                        else begin osh = P2; n_p2++; end
                    end else begin
                        osh = mem[sin[11:0]];
                    end
                    miso = osh[7];
                end else if (bitn > 24) begin
                    osh  = {osh[6:0], 1'b0};
                    miso = osh[7];
                end else begin
                    miso = 1'b0;
                end
            end
            sck_prev = sck;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [11:0] a, input logic [7:0] dv, input logic ev,
                        output int t_acc);
        @(negedge clk);
        start = 1'b1; addr = a; wdata = dv; erased_valid = ev;
        t_acc = cyc;
        @(negedge clk);
        start = 1'b0; erased_valid = 1'b0;
    endtask

    task automatic wait_done(input int prev);
        wait (done_cnt > prev);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; addr = '0; wdata = '0; erased_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 status idle",
            {busy, done, err}, 0);
        chk(sck == 1'b0 && mosi == 1'b0, "R1 serial lines low", {sck, mosi}, 0);
    endtask

    task automatic t_poll(input logic [11:0] a, input logic [7:0] dv, input logic ev);
        int w0, r0, p10, p20, d0, b0, ta;
        w0 = wr_frames; r0 = rd_frames; p10 = n_p1; p20 = n_p2; d0 = done_cnt; b0 = bad_frames;
        send(a, dv, ev, ta);
        wait_done(d0);
        chk(mem[a] == dv, "R2 target holds written byte", mem[a], dv);
        chk(wr_frames - w0 == 1 && bad_frames == b0, "R2 one well-formed write",
            wr_frames - w0, 1);
        chk(rd_frames > r0 && n_p1 > p10 && n_p2 > p20, "R3 polled through both markers",
            (n_p1 - p10) * 100 + (n_p2 - p20), 101);
        chk(fin_t >= ta && done_t > fin_t, "R4 completion after target finished",
            done_t, fin_t + 1);
        chk(done_err == 1'b0, "R3 no error on good poll", done_err, 0);
        chk(done_cnt - d0 == 1, "R10 one completion", done_cnt - d0, 1);
        if (ev) chk(wr_frames - w0 == 1, "R6 erase flag alone does not skip",
                    wr_frames - w0, 1);
    endtask

    task automatic t_timed(input logic [11:0] a, input logic [7:0] dv);
        int r0, d0, ta, gap;
        r0 = rd_frames; d0 = done_cnt;
        send(a, dv, 1'b0, ta);
        wait_done(d0);
        gap = done_t - last_fall;
        chk(rd_frames == r0, "R5 no reads for marker data", rd_frames - r0, 0);
        chk(gap >= TWD && gap <= TWD + 20, "R5 timed wait length", gap, TWD);
        chk(mem[a] == dv, "R2 marker byte stored", mem[a], dv);
    endtask

    task automatic t_skip();
        int w0, f0, d0, ta;
        w0 = wr_frames; f0 = sck_falls; d0 = done_cnt;
        send(12'h300, 8'hFF, 1'b1, ta);
        wait_done(d0);
        chk(sck_falls == f0 && wr_frames == w0, "R6 no serial traffic on skip",
            sck_falls - f0, 0);
        chk(done_t - ta <= 3, "R6 quick completion on skip", done_t - ta, 3);
        chk(mem[12'h300] == 8'h00, "R6 target untouched", mem[12'h300], 0);
    endtask

    task automatic t_ff_write();
        int w0, r0, d0, ta;
        w0 = wr_frames; r0 = rd_frames; d0 = done_cnt;
        send(12'h300, 8'hFF, 1'b0, ta);
        wait_done(d0);
        chk(wr_frames - w0 == 1, "R7 0xFF written without erase flag", wr_frames - w0, 1);
        chk(rd_frames > r0, "R7 0xFF polled", rd_frames - r0, 1);
        chk(mem[12'h300] == 8'hFF, "R7 target holds 0xFF", mem[12'h300], 255);
    endtask

    task automatic t_busy();
        int w0, d0, ta;
        w0 = wr_frames; d0 = done_cnt;
        send(12'h200, 8'h44, 1'b0, ta);
        repeat (40) @(negedge clk);
        chk(busy == 1'b1, "R8 engine occupied", busy, 1);
        start = 1'b1; addr = 12'h201; wdata = 8'h55;
        @(negedge clk);
        start = 1'b0;
        wait_done(d0);
        repeat (300) @(negedge clk);
        chk(wr_frames - w0 == 1, "R8 strobe while busy ignored", wr_frames - w0, 1);
        chk(done_cnt - d0 == 1, "R8 single completion", done_cnt - d0, 1);
        chk(mem[12'h200] == 8'h44 && mem[12'h201] == 8'h00, "R8 only first byte stored",
            mem[12'h201], 0);
    endtask

    task automatic t_timeout();
        int d0, ta;
        stuck = 1'b1; stuck_a = 12'h250;
        d0 = done_cnt;
        send(12'h250, 8'h66, 1'b0, ta);
        wait_done(d0);
        chk(done_err == 1'b1, "R9 error with completion", done_err, 1);
        chk(done_t - ta >= PLIM, "R9 gave up only after limit", done_t - ta, PLIM);
        repeat (20) @(negedge clk);
        chk(err == 1'b1, "R9 error stays set", err, 1);
        stuck = 1'b0;
        d0 = done_cnt;
        send(12'h251, 8'h21, 1'b0, ta);
        chk(err == 1'b0, "R9 error cleared on accept", err, 0);
        wait_done(d0);
        chk(done_err == 1'b0 && mem[12'h251] == 8'h21, "R9 next byte succeeds",
            done_err, 0);
    endtask

    initial begin
        stuck = 1'b0; stuck_a = '0;
        t_reset();
        t_poll(12'h123, 8'h5A, 1'b0);
        t_poll(12'hABC, 8'h01, 1'b0);
        t_poll(12'h0F0, 8'h3C, 1'b1);
        t_timed(12'h040, P1);
        t_timed(12'h041, P2);
        t_skip();
        t_ff_write();
        t_busy();
        t_timeout();
        chk(pulse_bad == 0, "R10 completion pulses one cycle wide", pulse_bad, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule